// File: doc/BRIEF.md
# Floating-Point Charge Code Linearizer

This block turns each compressed sample from a multi-range charge digitizer into a plain linear count. A sample arrives as a 6-bit mantissa, a 2-bit range exponent and a 2-bit phase tag, qualified by a valid strobe. The mantissa is decoded on a piecewise-linear scale whose step size doubles from one segment to the next. The decoded value is then scaled up by a factor of eight for each exponent step. The result is a 17-bit linear count.

The digitizer front end cycles through four phases. Each phase can carry a slightly different baseline, so the block keeps one 8-bit pedestal per phase tag and subtracts the selected pedestal from the linear count. If the pedestal is larger than the count, the result is clamped at zero and an underflow flag marks the sample. Pedestals are loaded through a small address/data/write-enable port. The datapath is a fixed two-stage pipeline that accepts a new sample on every clock.

Top module: `charge_code_linearizer`

## Requirements
- R1: While reset is active and right after it, out_valid, out_count and out_under are 0, and all four pedestals read as zero.
- R2: The mantissa splits into a segment s = in_mant[5:4] and a step k = in_mant[3:0]. Its linear position is 16*(2^s - 1) + k*2^s, so the step sizes are 1, 2, 4 and 8 and each segment starts where the one below it ends.
- R3: The linear position is multiplied by 8^e, where e = in_exp, which equals a left shift by 3*e.
- R4: ped_we high writes ped_wdata (8 bits) into pedestal entry ped_addr. The entry subtracted from a sample is the one selected by that sample's in_tag, and a write leaves the other three entries unchanged.
- R5: out_count is the scaled value minus the selected pedestal. When the pedestal exceeds the value, out_count is 0 and out_under is 1. A pedestal equal to the value gives 0 with out_under low.
- R6: out_valid equals in_valid delayed by exactly two clock cycles. Back-to-back samples produce back-to-back results with no gaps.
- R7: In a cycle where out_valid is low, out_count and out_under keep the values of the last valid result.
- R8: A sample taken in the same cycle as a write to its own pedestal entry uses the pedestal value from before the write. Samples in later cycles use the new value.
- R9: The largest possible result, for mantissa 63 and exponent 3 with a zero pedestal, is 118784, and out_count never exceeds it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_mant | input | 6 | Piecewise-linear mantissa code |
| in_exp | input | 2 | Range exponent, each step scales by 8 |
| in_tag | input | 2 | Phase tag, selects the pedestal |
| ped_we | input | 1 | Pedestal write enable |
| ped_addr | input | 2 | Pedestal entry to write |
| ped_wdata | input | 8 | Pedestal value to write |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_count | output | 17 | Linear count after pedestal subtraction |
| out_under | output | 1 | Set when the pedestal exceeded the value (count clamped to 0) |

## Verification
A pedestal write and a sample that reads the same entry can happen in the same clock cycle. The bench sets this up by raising ped_we for entry 0 in the very cycle it presents a phase-0 sample, then sends an identical sample in the following cycle. The first result must show the old pedestal subtracted and the second result the new one. This separates a correct read-before-write from a design that forwards the write data too early or applies it too late.

// File: rtl/lin_pkg.sv
package lin_pkg;
  localparam int MANT_W   = 6;
  localparam int SEG_W    = 2;
  localparam int EXP_W    = 2;
  localparam int TAG_W    = 2;
  localparam int PED_W    = 8;
  localparam int EXP_STEP = 3;

  localparam int STEP_W = MANT_W - SEG_W;
  localparam int NSEG   = 1 << SEG_W;
  localparam int NEXP   = 1 << EXP_W;
  localparam int NTAG   = 1 << TAG_W;
  localparam int LIN_W  = STEP_W + NSEG;
  localparam int OUT_W  = LIN_W + EXP_STEP * (NEXP - 1);

  localparam int LIN_MAX = (((1 << (NSEG - 1)) - 1) << STEP_W)
                         + (((1 << STEP_W) - 1) << (NSEG - 1));
  localparam int OUT_MAX = LIN_MAX << (EXP_STEP * (NEXP - 1));
endpackage

// File: rtl/lin_mantissa.sv
module lin_mantissa
  import lin_pkg::*;
(
  input  logic [MANT_W-1:0] code,
  output logic [LIN_W-1:0]  pos
);
  logic [SEG_W-1:0]  seg;
  logic [STEP_W-1:0] step;
  logic [LIN_W-1:0]  cand [NSEG];

  assign seg  = code[MANT_W-1:STEP_W];
  assign step = code[STEP_W-1:0];

  // one candidate per segment: segment base plus step scaled by its bin width
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam logic [LIN_W-1:0] BASE = LIN_W'(((1 << s) - 1) << STEP_W);
    assign cand[s] = BASE + (LIN_W'(step) << s);
  end

  assign pos = cand[seg];
endmodule

// File: rtl/lin_ped_bank.sv
module lin_ped_bank
  import lin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [TAG_W-1:0] waddr,
  input  logic [PED_W-1:0] wdata,
  input  logic [TAG_W-1:0] raddr,
  output logic [PED_W-1:0] rdata
);
  logic [PED_W-1:0] bank [NTAG];

  for (genvar t = 0; t < NTAG; t++) begin : g_ent
    logic             en;
    logic [PED_W-1:0] q;
    assign en = we && (waddr == TAG_W'(t));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign bank[t] = q;
  end

  assign rdata = bank[raddr];
endmodule

// File: rtl/lin_sub.sv
module lin_sub
  import lin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_in,
  input  logic [OUT_W-1:0] value,
  input  logic [PED_W-1:0] ped,
  output logic             v_out,
  output logic [OUT_W-1:0] count,
  output logic             under
);
  logic [OUT_W:0]   diff;
  logic [OUT_W-1:0] cnt_d;
  logic             und_d;

  always_comb begin
    diff  = {1'b0, value} - {1'b0, (OUT_W)'(ped)};
    und_d = diff[OUT_W];
    cnt_d = und_d ? '0 : diff[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out <= 1'b0;
      count <= '0;
      under <= 1'b0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        count <= cnt_d;
        under <= und_d;
      end
    end
  end
endmodule

// File: rtl/charge_code_linearizer.sv
module charge_code_linearizer
  import lin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MANT_W-1:0] in_mant,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              ped_we,
  input  logic [TAG_W-1:0]  ped_addr,
  input  logic [PED_W-1:0]  ped_wdata,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_count,
  output logic              out_under
);
  logic [LIN_W-1:0] lin_pos;
  logic [PED_W-1:0] ped_sel;
  logic [OUT_W-1:0] scaled_d;

  logic             s1_valid_q;
  logic [OUT_W-1:0] s1_value_q;
  logic [PED_W-1:0] s1_ped_q;

  lin_mantissa u_mant (
    .code (in_mant),
    .pos  (lin_pos)
  );

  lin_ped_bank u_ped (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ped_we),
    .waddr (ped_addr),
    .wdata (ped_wdata),
    .raddr (in_tag),
    .rdata (ped_sel)
  );

  // stage 1 next state: range scaling
  always_comb begin
    scaled_d = (OUT_W)'(lin_pos) << (EXP_STEP * int'(in_exp));
  end

  // stage 1 registers: pedestal is captured before any same-cycle write lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_value_q <= '0;
      s1_ped_q   <= '0;
    end else begin
      s1_valid_q <= in_valid;
      if (in_valid) begin
        s1_value_q <= scaled_d;
        s1_ped_q   <= ped_sel;
      end
    end
  end

  lin_sub u_sub (
    .clk   (clk),
    .rst_n (rst_n),
    .v_in  (s1_valid_q),
    .value (s1_value_q),
    .ped   (s1_ped_q),
    .v_out (out_valid),
    .count (out_count),
    .under (out_under)
  );
endmodule

// File: rtl/lin_checker.sv
module lin_checker
  import lin_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_count,
  input logic             out_under
);
  AST_VALID_TWO_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);                                  // R6
  AST_IDLE_TWO_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);                                // R6
  AST_UNDER_CLAMPS: assert property (@(posedge clk) disable iff (!rst_n)
    out_under |-> (out_count == '0));                             // R5
  AST_COUNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    out_count <= (OUT_W)'(OUT_MAX));                              // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_count) && $stable(out_under)));  // R7
endmodule

bind charge_code_linearizer lin_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_count (out_count),
  .out_under (out_under)
);

// File: tb/sim_charge_code_linearizer.sv
module sim_charge_code_linearizer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [5:0]  in_mant;
  logic [1:0]  in_exp;
  logic [1:0]  in_tag;
  logic        ped_we;
  logic [1:0]  ped_addr;
  logic [7:0]  ped_wdata;
  logic        out_valid;
  logic [16:0] out_count;
  logic        out_under;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  charge_code_linearizer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mant(in_mant),
    .in_exp(in_exp), .in_tag(in_tag), .ped_we(ped_we), .ped_addr(ped_addr),
    .ped_wdata(ped_wdata), .out_valid(out_valid), .out_count(out_count),
    .out_under(out_under)
  );

  // {mant, exp, tag, expected count, expected under}; pedestals 0,5,20,200
  localparam int NV = 14;
  localparam logic [27:0] VEC [NV] = '{
    {6'd0,  2'd0, 2'd0, 17'd0,      1'b0},
    {6'd15, 2'd0, 2'd0, 17'd15,     1'b0},
    {6'd16, 2'd0, 2'd0, 17'd16,     1'b0},
    {6'd17, 2'd1, 2'd1, 17'd139,    1'b0},
    {6'd47, 2'd2, 2'd2, 17'd6892,   1'b0},
    {6'd48, 2'd3, 2'd3, 17'd57144,  1'b0},
    {6'd63, 2'd3, 2'd0, 17'd118784, 1'b0},
    {6'd3,  2'd0, 2'd1, 17'd0,      1'b1},
    {6'd5,  2'd0, 2'd1, 17'd0,      1'b0},
    {6'd33, 2'd0, 2'd3, 17'd0,      1'b1},
    {6'd32, 2'd1, 2'd3, 17'd184,    1'b0},
    {6'd31, 2'd2, 2'd2, 17'd2924,   1'b0},
    {6'd10, 2'd3, 2'd1, 17'd5115,   1'b0},
    {6'd20, 2'd0, 2'd2, 17'd4,      1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic write_ped(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    ped_we = 1'b1; ped_addr = a; ped_wdata = d;
    @(negedge clk);
    ped_we = 1'b0;
  endtask

  // single sample, result sampled two negedges after it is driven
  task automatic send(input logic [5:0] m, input logic [1:0] e, input logic [1:0] t,
                      input int ecnt, input int eund, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_mant = m; in_exp = e; in_tag = t;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " count"}, int'(out_count), ecnt);
    check({req, " under"}, int'(out_under), eund);
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL R6: watchdog expired, actual running expected done");
    summary();
    $finish;
  end

  initial begin
    logic       pv0, pv1, pu0, pu1;
    int         pc0, pc1;
    rst_n = 1'b0; in_valid = 1'b0; in_mant = '0; in_exp = '0; in_tag = '0;
    ped_we = 1'b0; ped_addr = '0; ped_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset count", int'(out_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset valid", int'(out_valid), 0);
    check("R1 post-reset under", int'(out_under), 0);

    // R1: every pedestal entry starts at zero
    for (int t = 0; t < 4; t++) send(6'd15, 2'd0, 2'(t), 15, 0, "R1 pedestal zero");

    write_ped(2'd1, 8'd5);
    write_ped(2'd2, 8'd20);
    write_ped(2'd3, 8'd200);

    // table walk, back-to-back samples (R2 R3 R4 R5 R6 R9)
    pv0 = 1'b0; pv1 = 1'b0; pc0 = 0; pc1 = 0; pu0 = 1'b0; pu1 = 1'b0;
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      check($sformatf("R6 stream valid %0d", i), int'(out_valid), int'(pv1));
      if (pv1) begin
        check($sformatf("R2 R3 R4 count %0d", i - 2), int'(out_count), pc1);
        check($sformatf("R5 under %0d", i - 2), int'(out_under), int'(pu1));
      end
      pv1 = pv0; pc1 = pc0; pu1 = pu0;
      if (i < NV) begin
        in_valid = 1'b1;
        in_mant  = VEC[i][27:22];
        in_exp   = VEC[i][21:20];
        in_tag   = VEC[i][19:18];
        pv0 = 1'b1; pc0 = int'(VEC[i][17:1]); pu0 = VEC[i][0];
      end else begin
        in_valid = 1'b0;
        pv0 = 1'b0;
      end
    end

    // R7: idle cycles keep the last result (vector 13: count 4)
    repeat (3) @(negedge clk);
    check("R7 idle valid", int'(out_valid), 0);
    check("R7 idle count held", int'(out_count), 4);
    check("R7 idle under held", int'(out_under), 0);

    // R8: write to entry 0 in the same cycle as a phase-0 sample
    @(negedge clk);
    in_valid = 1'b1; in_mant = 6'd15; in_exp = 2'd0; in_tag = 2'd0;
    ped_we = 1'b1; ped_addr = 2'd0; ped_wdata = 8'd10;
    @(negedge clk);
    ped_we = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 same-cycle old pedestal", int'(out_count), 15);
    @(negedge clk);
    check("R8 next-cycle new pedestal", int'(out_count), 5);

    // R4: writing entry 0 left entry 3 alone (200 > 52 -> clamp)
    send(6'd33, 2'd0, 2'd3, 0, 1, "R4 other entry kept");
    // R5: underflow then normal sample clears flag
    send(6'd63, 2'd0, 2'd3, 32, 0, "R5 flag clears");
    // R9: top of scale
    send(6'd63, 2'd3, 2'd1, 118779, 0, "R9 top code");

    // R1: reset in the middle of operation clears pedestals
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset valid", int'(out_valid), 0);
    check("R1 mid reset count", int'(out_count), 0);
    rst_n = 1'b1;
    send(6'd15, 2'd0, 2'd3, 15, 0, "R1 pedestal cleared");

    summary();
    $finish;
  end
endmodule